// File: doc/BRIEF.md
# Tiled Window Raster Address Generator

This block turns a pair of 8-bit window bytes into a rectangular region of interest on a 128 × 128 pixel grid. The grid is split into 16 × 16 tiles of 8 × 8 pixels. Each byte carries a column tile index in its low nibble and a row tile index in its high nibble. The start byte gives the first tile, inclusive. The end byte gives the bounding tile, exclusive. When an end index is not greater than the matching start index, that end index is replaced by 16, which is the far edge of the grid. The replacement is made for each axis on its own. With both bytes at 00h the whole frame is covered.

A one-cycle `go` pulse latches both bytes and starts a scan. From then on the block walks the window in raster order: the column advances fastest, and the row steps when the column wraps. The block emits one coordinate for each clock in which `advance` is high. A strobe marks every emitted coordinate, and `winActive` stays high for the whole scan. A single-cycle `scanDone` pulse follows the final pixel. A downstream pixel reader uses the address and strobe to fetch only the window's pixels.

Top module: `winScanAddrGen`

## Requirements
- R1: After reset, `winActive`, `pixStrobe` and `scanDone` are 0 and `pixX`/`pixY` are 0.
- R2: A `go` pulse while idle latches the bytes. From the next clock, `winActive` is 1 and `pixX`/`pixY` show (8·startByte[3:0], 8·startByte[7:4]).
- R3: The column bound is endByte[3:0] if it is greater than startByte[3:0], and 16 otherwise. The row bound is decided from endByte[7:4] and startByte[7:4] in the same way, independently of the column.
- R4: Coordinates run in raster order. The column runs from 8·start to 8·bound−1, and after that column it wraps back to 8·start while the row increments. The last pixel is (8·colBound−1, 8·rowBound−1).
- R5: `pixStrobe` is high exactly when `winActive` and `advance` are both high. The coordinate is held while `advance` is low.
- R6: The clock after the strobe of the last pixel, `winActive` is 0 and `scanDone` is 1 for exactly one cycle.
- R7: A `go` pulse while `winActive` is high has no effect on the ongoing coordinate sequence.
- R8: Bytes 00h/00h scan all 16384 pixels, from (0,0) to (127,127).
- R9: Bytes 55h/66h cover columns and rows 40 to 47. Bytes 01h/02h cover columns 8 to 15 and rows 0 to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startByte | input | 8 | First tile: column in [3:0], row in [7:4] |
| endByte | input | 8 | Exclusive bound tile: column in [3:0], row in [7:4] |
| go | input | 1 | Start pulse, honoured only while idle |
| advance | input | 1 | Emit one coordinate this clock |
| pixX | output | 7 | Current pixel column |
| pixY | output | 7 | Current pixel row |
| pixStrobe | output | 1 | Coordinate on pixX/pixY is emitted this cycle |
| winActive | output | 1 | Scan in progress |
| scanDone | output | 1 | One-cycle pulse after the final pixel |

## Verification
The strobe responds to `advance` in the same cycle. The first coordinate appears one clock after the accepted `go`. Each further coordinate appears one clock after the strobe before it, and `scanDone` rises one clock after the final strobe. The bench changes inputs just after each rising edge and samples on the falling edge. The monitor therefore compares each strobed coordinate against the scoreboard head in the cycle it is emitted. The done pulse and its return to 0 are checked on the two falling edges that follow.

// File: rtl/winScanPkg.sv
package winScanPkg;
  typedef struct packed {
    logic load;
    logic step;
  } winStrobes_t;
endpackage

// File: rtl/winScanCtrl.sv
module winScanCtrl
  import winScanPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        go,
  input  logic        advance,
  input  logic        isLast,
  output winStrobes_t strobes,
  output logic        active,
  output logic        done
);
  always_comb begin
    strobes.load = go & ~active;
    strobes.step = active & advance;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= strobes.step & isLast;
      if (strobes.load)
        active <= 1'b1;
      else if (strobes.step && isLast)
        active <= 1'b0;
    end
  end
endmodule

// File: rtl/winScanDatapath.sv
module winScanDatapath
  import winScanPkg::*;
#(
  parameter int TILE_W = 4,
  parameter int SUB_W  = 3,
  localparam int COORD_W = TILE_W + SUB_W,
  localparam int BYTE_W  = 2 * TILE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  winStrobes_t        strobes,
  input  logic [BYTE_W-1:0]  startByte,
  input  logic [BYTE_W-1:0]  endByte,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic               isLast
);
  localparam int AXES  = 2;
  localparam int TILES = 1 << TILE_W;

  logic [COORD_W-1:0] coord [AXES];
  logic [AXES-1:0]    atLast;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [TILE_W-1:0]  startRaw, endRaw, startTile;
    logic [TILE_W:0]    endTile, boundTile;
    logic [COORD_W:0]   lastExt;
    logic [COORD_W-1:0] lastPix, firstPix;
    logic               axisStep;

    assign startRaw = startByte[a*TILE_W +: TILE_W];
    assign endRaw   = endByte[a*TILE_W +: TILE_W];
    // exclusive bound, clamped to the grid edge when not beyond the start
    assign boundTile = (endRaw > startRaw) ? {1'b0, endRaw} : (TILE_W+1)'(TILES);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startTile <= '0;
        endTile   <= '0;
      end else if (strobes.load) begin
        startTile <= startRaw;
        endTile   <= boundTile;
      end
    end

    assign firstPix = {startTile, {SUB_W{1'b0}}};
    assign lastExt  = {endTile, {SUB_W{1'b0}}} - (COORD_W+1)'(1);
    assign lastPix  = lastExt[COORD_W-1:0];
    assign atLast[a] = (coord[a] == lastPix);

    if (a == 0) begin : g_fast
      assign axisStep = strobes.step;
    end else begin : g_slow
      assign axisStep = strobes.step & (&atLast[a-1:0]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        coord[a] <= '0;
      else if (strobes.load)
        coord[a] <= {startRaw, {SUB_W{1'b0}}};
      else if (axisStep)
        coord[a] <= atLast[a] ? firstPix : coord[a] + COORD_W'(1);
    end
  end

  assign pixX   = coord[0];
  assign pixY   = coord[1];
  assign isLast = &atLast;
endmodule

// File: rtl/winScanAddrGen.sv
module winScanAddrGen
  import winScanPkg::*;
#(
  parameter int TILE_W = 4,
  parameter int SUB_W  = 3,
  localparam int COORD_W = TILE_W + SUB_W,
  localparam int BYTE_W  = 2 * TILE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BYTE_W-1:0]  startByte,
  input  logic [BYTE_W-1:0]  endByte,
  input  logic               go,
  input  logic               advance,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic               pixStrobe,
  output logic               winActive,
  output logic               scanDone
);
  winStrobes_t strobes;
  logic        isLast;

  winScanCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .go(go), .advance(advance), .isLast(isLast),
    .strobes(strobes), .active(winActive), .done(scanDone)
  );

  winScanDatapath #(.TILE_W(TILE_W), .SUB_W(SUB_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .startByte(startByte), .endByte(endByte),
    .pixX(pixX), .pixY(pixY), .isLast(isLast)
  );

  assign pixStrobe = strobes.step;
endmodule

// File: rtl/winScanAddrGen_chk.sv
module winScanAddrGen_chk #(
  parameter int COORD_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               go,
  input logic               advance,
  input logic [COORD_W-1:0] pixX,
  input logic [COORD_W-1:0] pixY,
  input logic               pixStrobe,
  input logic               winActive,
  input logic               scanDone
);
  p_start_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!winActive && go) |=> (winActive && pixX[2:0] == 3'd0 && pixY[2:0] == 3'd0));

  p_raster_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (winActive && advance) |=> (!winActive
      || (pixY == $past(pixY) && pixX == COORD_W'($past(pixX) + 1'b1))
      || (pixY == COORD_W'($past(pixY) + 1'b1))));

  p_strobe_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixStrobe |-> winActive);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (winActive && !advance) |=> (winActive && $stable(pixX) && $stable(pixY)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  p_done_on_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(winActive) |-> scanDone);

  p_go_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (winActive && go && !advance) |=> ($stable(pixX) && $stable(pixY)));
endmodule

bind winScanAddrGen winScanAddrGen_chk #(.COORD_W(COORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .go(go), .advance(advance), .pixX(pixX), .pixY(pixY),
  .pixStrobe(pixStrobe), .winActive(winActive), .scanDone(scanDone)
);

// File: tb/winScanAddrGen_tb_top.sv
module winScanAddrGen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] startByte = '0, endByte = '0;
  logic go = 1'b0, advance = 1'b0;
  logic [6:0] pixX, pixY;
  logic pixStrobe, winActive, scanDone;

  int checks = 0, failures = 0, cycles = 0;
  int strobeSeen = 0;
  string curTag = "R4";
  logic [13:0] expQ[$];

  always #4 clk = ~clk;

  winScanAddrGen dut_i (
    .clk(clk), .rstN(rstN), .startByte(startByte), .endByte(endByte),
    .go(go), .advance(advance), .pixX(pixX), .pixY(pixY),
    .pixStrobe(pixStrobe), .winActive(winActive), .scanDone(scanDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare each strobed coordinate with the scoreboard head
  always @(negedge clk) begin
    if (rstN) begin
      check(pixStrobe == (winActive && advance), "R5 strobe", pixStrobe, winActive && advance);
      if (pixStrobe) begin
        strobeSeen++;
        if (expQ.size() == 0)
          check(1'b0, {curTag, " unexpected coordinate"}, {pixY, pixX}, -1);
        else begin
          logic [13:0] e;
          e = expQ.pop_front();
          check({pixY, pixX} == e, {curTag, " coordinate {y,x}"}, {pixY, pixX}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // driver: push expected raster, then run the scan
  // mode 0: advance always, 1: every other cycle, 2: two of three,
  // 3: every other cycle plus a go pulse in mid-scan (R7)
  task automatic runScan(input logic [7:0] st, input logic [7:0] en,
                         input int mode, input string tag);
    int xs, xe, ys, ye, n, cyc;
    xs = st[3:0] * 8; ys = st[7:4] * 8;
    xe = (en[3:0] > st[3:0]) ? en[3:0] * 8 : 128;   // R3
    ye = (en[7:4] > st[7:4]) ? en[7:4] * 8 : 128;
    n = 0;
    for (int y = ys; y < ye; y++)
      for (int x = xs; x < xe; x++) begin
        expQ.push_back({7'(y), 7'(x)});
        n++;
      end
    curTag = tag;
    strobeSeen = 0;
    @(posedge clk); #1;
    startByte = st; endByte = en; go = 1'b1; advance = 1'b0;
    @(posedge clk); #1;
    go = 1'b0;
    @(negedge clk);
    check(winActive == 1'b1, "R2 active after go", winActive, 1);
    check({pixY, pixX} == {7'(ys), 7'(xs)}, "R2 first coordinate", {pixY, pixX}, {7'(ys), 7'(xs)});
    cyc = 0;
    forever begin
      @(posedge clk); #1;
      case (mode)
        0: advance = 1'b1;
        2: advance = (cyc % 3) != 0;
        default: advance = cyc[0];
      endcase
      if (mode == 3 && cyc == 6) begin
        go = 1'b1; startByte = 8'h00; endByte = 8'h00;
      end else go = 1'b0;
      cyc++;
      @(negedge clk);
      if (scanDone) break;
    end
    advance = 1'b0; go = 1'b0;
    check(winActive == 1'b0, "R6 inactive with done", winActive, 0);
    check(expQ.size() == 0, {tag, " all pixels emitted"}, expQ.size(), 0);
    check(strobeSeen == n, {tag, " strobe count"}, strobeSeen, n);
    @(negedge clk);
    check(scanDone == 1'b0, "R6 done single cycle", scanDone, 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!winActive && !pixStrobe && !scanDone, "R1 reset flags", {winActive, pixStrobe, scanDone}, 0);
    check(pixX == 0 && pixY == 0, "R1 reset coordinate", {pixY, pixX}, 0);
    #1 rstN = 1'b1;
    runScan(8'h00, 8'h00, 0, "R8");
    runScan(8'h55, 8'h66, 1, "R9");
    runScan(8'h01, 8'h02, 2, "R9");
    runScan(8'h33, 8'h21, 0, "R3");
    runScan(8'h44, 8'h44, 2, "R3");
    runScan(8'hA2, 8'hC6, 3, "R7");
    runScan(8'h7E, 8'h8F, 0, "R4");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule